// File: doc/BRIEF.md
# Two-Port GPIO Register Bank

This block holds the register state behind a bank of general-purpose pins. The pins are grouped into byte-wide ports. Each port has three registers: a drive-value register, a direction register and a read-inversion mask. The block also takes in the pin levels, resynchronised to the local clock. A byte-wide read/write strobe interface, indexed by a small address, gives access to every register. Each pin gets a drive value and an output enable for a tri-state pad.

A read strobe captures the selected byte into a read-data register, which then holds its value until the next read strobe. For an input address, the captured byte is the synchronised pin level XORed with that port's inversion mask. The capture happens at the strobe edge itself. This matches a serial host that samples port data during the acknowledge slot just before it shifts the byte out.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1 (pin_oe all 0), every drive-value bit is 1 (pin_out all 1), every inversion bit is 0 and rdata is 0.
- R2: A direction bit of 1 makes its pin an input with the driver off (pin_oe bit 0). A direction bit of 0 enables the driver (pin_oe bit 1).
- R3: pin_out always shows the drive-value register. A pin whose direction bit is 1 keeps pin_oe at 0 whatever value that register holds.
- R4: The upper two address bits select the register kind: 0 input, 1 drive value, 2 inversion mask, 3 direction. The low address bit selects the port, and port 0 owns pins 7:0.
- R5: A write strobe changes only the one addressed byte register. The other port's register of the same kind does not change.
- R6: A read of an input address returns the synchronised pin byte XORed bit by bit with that port's inversion mask.
- R7: Input reads show pin levels whether or not the pin is configured as an output.
- R8: A read of a drive-value address returns the stored register value, not the level on the pins.
- R9: Writes to input addresses change no register state.
- R10: rdata is loaded only on the clock edge of a read strobe. A pin change becomes visible to a read after SYNC_STAGES edges. rdata holds its value between strobes.
- R11: Reads of inversion-mask and direction addresses return the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, the input capture point |
| addr | input | ADDR_W (3) | Register index: {kind, port} |
| wdata | input | PORT_W (8) | Write data |
| rdata | output | PORT_W (8) | Captured read data |
| pin_in | input | PIN_W (16) | Pad input levels |
| pin_out | output | PIN_W (16) | Pad drive values |
| pin_oe | output | PIN_W (16) | Pad output enables |

## Verification
The bench builds the block with its defaults: two ports of eight bits and a two-stage synchroniser. Two ports are the smallest set in which a write to one byte can be shown to leave its partner alone. The two-stage depth lets the bench place back-to-back read strobes so that exactly two reads return the old pin byte and the third returns the new one, which pins down the capture edge. Pins are driven apart from the drive values on output-configured bits, so that input reads and drive-value reads visibly differ.

// File: rtl/gpio_bank_pkg.sv
// Shared types for the GPIO register bank.
package gpio_bank_pkg;
    // Register kind, carried in the upper two address bits.
    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_DIR = 2'd3
    } reg_kind_e;
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchroniser for pad inputs.
// Assumes: STAGES >= 1; inputs may be asynchronous to clk.
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d;
                else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
// One byte-wide port: drive value, inversion mask and direction registers.
// Assumes: the write strobes are already decoded and at most one is set per cycle.
module gpio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_out,
    input  logic         wr_pol,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] pol_q,
    output logic [W-1:0] dir_q
);
    // Drive-value register, reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '1;
        else if (wr_out) out_q <= wdata;
    end

    // Inversion mask, reset to pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= '0;
        else if (wr_pol) pol_q <= wdata;
    end

    // Direction register, reset to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO register bank: byte ports with direction, drive value and read
// inversion, plus input capture at the read strobe.
// Assumes: the host issues single-cycle strobes; addresses past the last
// port read as zero and write nothing.
module gpio_bank #(
    parameter int PORT_W      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W  = PORT_W * NUM_PORTS,
    localparam int SEL_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W = 2 + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    import gpio_bank_pkg::*;

    reg_kind_e         kind;
    logic [SEL_W-1:0]  sel;
    logic [PIN_W-1:0]  pin_sync;
    logic [PORT_W-1:0] out_q [NUM_PORTS];
    logic [PORT_W-1:0] pol_q [NUM_PORTS];
    logic [PORT_W-1:0] dir_q [NUM_PORTS];
    logic [PORT_W-1:0] rd_mux;

    assign kind = reg_kind_e'(addr[ADDR_W-1 -: 2]);
    assign sel  = addr[SEL_W-1:0];

    gpio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = wr_en && (sel == SEL_W'(p));

            gpio_port #(.W(PORT_W)) u_port (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_out(hit && kind == KIND_OUT),
                .wr_pol(hit && kind == KIND_POL),
                .wr_dir(hit && kind == KIND_DIR),
                .wdata (wdata),
                .out_q (out_q[p]),
                .pol_q (pol_q[p]),
                .dir_q (dir_q[p])
            );

            assign pin_out[p*PORT_W +: PORT_W] = out_q[p];
            assign pin_oe [p*PORT_W +: PORT_W] = ~dir_q[p];

            // R2: a direction write sets the enables to its inverse.
            a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && kind == KIND_DIR && sel == SEL_W'(p))
                |=> pin_oe[p*PORT_W +: PORT_W] == ~$past(wdata));

            // R3: a drive-value write shows on the pins next cycle.
            a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && kind == KIND_OUT && sel == SEL_W'(p))
                |=> pin_out[p*PORT_W +: PORT_W] == $past(wdata));

            // R5: without a write to this byte, its drive value holds.
            a_r5_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && kind == KIND_OUT && sel == SEL_W'(p))
                |=> $stable(pin_out[p*PORT_W +: PORT_W]));

            // R6: an input read returns the synchronised pins through the mask.
            a_r6_input_read: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && kind == KIND_IN && sel == SEL_W'(p))
                |=> rdata == $past(pin_sync[p*PORT_W +: PORT_W] ^ pol_q[p]));

            // R8: a drive-value read returns the register, not the pins.
            a_r8_out_read: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && kind == KIND_OUT && sel == SEL_W'(p))
                |=> rdata == $past(pin_out[p*PORT_W +: PORT_W]));
        end
    endgenerate

    // Select the byte a read strobe would capture.
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel == SEL_W'(p)) begin
                case (kind)
                    KIND_IN:  rd_mux = pin_sync[p*PORT_W +: PORT_W] ^ pol_q[p];
                    KIND_OUT: rd_mux = out_q[p];
                    KIND_POL: rd_mux = pol_q[p];
                    default:  rd_mux = dir_q[p];
                endcase
            end
        end
    end

    // Capture read data on the strobe edge and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R1: reset leaves all pins undriven at ones and rdata clear.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pin_oe == '0 && pin_out == '1 && rdata == '0));

    // R10: rdata changes only on a read strobe edge.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic rd_fire = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one-cycle write strobe.
    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: one-cycle read strobe with its expected byte queued.
    task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: note which edges carried a read strobe.
    always @(posedge clk) rd_fire <= rd_en;

    // Monitor: compare captured data half a cycle after the strobe edge.
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard actual=%h expected=none", rdata);
            end else begin
                chk(tag_q.pop_front(), {8'h00, rdata}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 oe", pin_oe, 16'h0000);
        chk("R1 out", pin_out, 16'hFFFF);
        chk("R1 rdata", {8'h00, rdata}, 16'h0000);
        rd(3'd2, 8'hFF, "R1 out0 read");
        rd(3'd4, 8'h00, "R1 R11 pol0 read");
        rd(3'd7, 8'hFF, "R1 R11 dir1 read");

        // R4 R6: pin bytes land in the right ports, mask clear
        pin_in = 16'hA55A;
        repeat (3) @(negedge clk);
        rd(3'd0, 8'h5A, "R4 R6 in0");
        rd(3'd1, 8'hA5, "R4 R6 in1");

        // R6: inversion mask on port 0 only
        wr(3'd4, 8'h0F);
        rd(3'd0, 8'h55, "R6 in0 inverted");
        rd(3'd1, 8'hA5, "R5 in1 not inverted");

        // R3 R5: drive value of port 1, port 0 untouched, pins still inputs
        wr(3'd3, 8'h3C);
        chk("R3 R5 out", pin_out, 16'h3CFF);
        chk("R3 oe stays off", pin_oe, 16'h0000);

        // R2: upper nibble of port 0 inputs, lower nibble outputs
        wr(3'd6, 8'hF0);
        chk("R2 oe", pin_oe, 16'h000F);
        rd(3'd6, 8'hF0, "R11 dir0");
        rd(3'd7, 8'hFF, "R5 dir1 kept");

        // R7 R8: pins disagree with drive values on output bits
        pin_in = 16'hA500;
        repeat (3) @(negedge clk);
        rd(3'd0, 8'h0F, "R7 in0 on outputs");
        rd(3'd2, 8'hFF, "R8 out0 latched");

        // R9: writes to input addresses change nothing
        wr(3'd0, 8'h77);
        wr(3'd1, 8'h77);
        chk("R9 out", pin_out, 16'h3CFF);
        chk("R9 oe", pin_oe, 16'h000F);
        rd(3'd0, 8'h0F, "R9 in0");
        rd(3'd1, 8'hA5, "R9 in1");
        rd(3'd4, 8'h0F, "R9 pol0");

        // R5 R8: second drive-value byte
        wr(3'd2, 8'h12);
        chk("R5 out both", pin_out, 16'h3C12);
        rd(3'd3, 8'h3C, "R8 out1");
        rd(3'd2, 8'h12, "R8 out0");

        // R10: change pins then read on three consecutive edges
        pin_in = 16'h3C00;
        rd(3'd1, 8'hA5, "R10 edge1 old");
        rd(3'd1, 8'hA5, "R10 edge2 old");
        rd(3'd1, 8'h3C, "R10 edge3 new");
        pin_in = 16'h0000;
        repeat (4) @(negedge clk);
        chk("R10 hold", {8'h00, rdata}, 16'h003C);

        repeat (2) @(negedge clk);
        chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule